// File: doc/BRIEF.md
# Program Memory Block Access Guard

This block sits between a processor's table-access path and its program memory array and decides, access by access, whether a table read or table write may proceed. Each access presents the address of the instruction being executed and the target address. Both are mapped to protection regions: a small boot region at the bottom of the address space followed by a set of equally sized main regions whose size is a parameter (16 KB or 8 KB, aligned to that size). Each region owns one write-guard bit and one read-guard bit; a bit at 1 means the region is open, a bit at 0 means it is guarded.

A guarded write is held off the array (no write-enable) and flagged. A guarded read is allowed only when the executing instruction lies in the same region as the target; otherwise the read still completes but returns an all-zeros word, and it is flagged. The flag is a one-cycle pulse in the cycle after the refused access.

The block also stores the guard bits. They come out of reset at 1. Software writes can only lower bits (the new value is the old value ANDed with the written value). Only an erase command raises bits again, either for a single region or for every region at once. Targets above the last main region are ignored: they produce no write-enable, no flag, and reads pass through unchanged.

Top module: `fguard_top`

## Requirements
- R1: A write access (accValid=1, accWrite=1) whose target region has its write-guard bit at 0 leaves memWrEn at 0, and violation is 1 in the following cycle only.
- R2: A read access whose target region has its read-guard bit at 0 and whose pcAddr lies in a different region (or above the last region) drives zeroSel=1 and rdDataOut=0 in the same cycle, and violation is 1 in the following cycle only.
- R3: An access to an open region, or a read whose pcAddr lies in the target's own region, passes: a write drives memWrEn=1 in the same cycle, a read drives rdDataOut=memRdData; violation stays 0 in the following cycle.
- R4: Region map: addresses 0x000000 to 0x0001FF form the boot region (guard bit index 0); main region k covers addresses from k*2^BLK_LOG2 (but starting at 0x000200 for k=0) up to (k+1)*2^BLK_LOG2-1 and uses guard bit index k+1. With the default BLK_LOG2=14 the boundaries are 0x4000, 0x8000, 0xC000.
- R5: A configuration write (cfgWrEn=1) sets each guard bit to its old value AND the written value; a 0-to-1 attempt leaves the bit at 0.
- R6: An erase command (eraseReq=1) sets, at the next clock edge, both guard bits of every region when eraseAll=1, or of region eraseIdx (same numbering as R4) when eraseAll=0; other regions are unchanged. If a configuration write coincides, the erase wins for the erased bits.
- R7: After reset all guard bits are 1 and memWrEn, zeroSel and violation are 0 while no access is presented.
- R8: A target at or above NUM_MAIN*2^BLK_LOG2 produces memWrEn=0, zeroSel=0, rdDataOut=memRdData and no violation, regardless of guard bits.
- R9: Write guard and read guard of a region act independently: a read-guarded region accepts writes while its write-guard bit is 1, and a write-guarded region serves reads while its read-guard bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | Table access strobe |
| accWrite | input | 1 | 1 = table write, 0 = table read |
| pcAddr | input | ADDR_W | Address of the executing instruction |
| tgtAddr | input | ADDR_W | Target address of the access |
| memRdData | input | DATA_W | Word read from the memory array |
| cfgWrEn | input | 1 | Software write of the guard bits |
| cfgWrProtIn | input | NUM_MAIN+1 | Written write-guard bits (bit 0 boot, bit k+1 main k) |
| cfgRdProtIn | input | NUM_MAIN+1 | Written read-guard bits (same layout) |
| eraseReq | input | 1 | Erase command |
| eraseAll | input | 1 | Erase covers every region |
| eraseIdx | input | IDX_W | Region index erased when eraseAll=0 |
| memWrEn | output | 1 | Write-enable to the memory array |
| zeroSel | output | 1 | Read data forced to zero |
| rdDataOut | output | DATA_W | Read data returned to the processor |
| violation | output | 1 | One-cycle pulse after a refused access |
| wrProtBits | output | NUM_MAIN+1 | Current write-guard bits |
| rdProtBits | output | NUM_MAIN+1 | Current read-guard bits |

## Verification
The bench goes after region edges (0x1FF/0x200 between boot and main 0, 0x3FFF/0x4000 between main 0 and 1, and the first address past the last region); an off-by-one mapper would guard the wrong side of an edge and either corrupt a neighbour or leak its data. It tries to raise a lowered bit by a configuration write, which a design that stores the written value instead of ANDing would accept, and it issues an erase together with a configuration write, where a wrong priority would leave the erased region guarded. It reads a guarded region both from inside and from outside that region, from the boot region and from above the map, so a design that ignored the executing address or compared raw addresses instead of regions returns wrong data or a wrong flag.

// File: rtl/fguard_pkg.sv
package fguard_pkg;

  // Strobes from the decision logic to the datapath
  typedef struct packed {
    logic wrPass;    // write may reach the array
    logic rdZero;    // read data must be forced to zero
    logic refuse;    // access refused, raise the flag next cycle
    logic cfgUpd;    // apply a software guard-bit write
    logic eraseUpd;  // apply an erase command
  } guardStrobes_t;

endpackage

// File: rtl/fguard_blkmap.sv
module fguard_blkmap #(
  parameter int ADDR_W   = 21,
  parameter int BLK_LOG2 = 14,
  parameter int NUM_MAIN = 4,
  parameter int BOOT_END = 512,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              inRange
);

  localparam int MW = ADDR_W - BLK_LOG2;
  localparam logic [MW-1:0]     MAIN_LIM = MW'(NUM_MAIN);
  localparam logic [ADDR_W-1:0] BOOT_LIM = ADDR_W'(BOOT_END);

  logic [MW-1:0] mainNum;
  assign mainNum = addr[ADDR_W-1:BLK_LOG2];

  // Index 0 is the boot region, k+1 is main region k
  always_comb begin
    if (addr < BOOT_LIM) begin
      idx     = '0;
      inRange = 1'b1;
    end else if (mainNum < MAIN_LIM) begin
      idx     = IDX_W'(mainNum) + IDX_W'(1);
      inRange = 1'b1;
    end else begin
      idx     = '0;
      inRange = 1'b0;
    end
  end

endmodule

// File: rtl/fguard_ctrl.sv
module fguard_ctrl
  import fguard_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int BLK_LOG2 = 14,
  parameter int NUM_MAIN = 4,
  parameter int BOOT_END = 512,
  parameter int NB       = NUM_MAIN + 1,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic              cfgWrEn,
  input  logic              eraseReq,
  input  logic [NB-1:0]     wrProt,
  input  logic [NB-1:0]     rdProt,
  output guardStrobes_t     strobes
);

  localparam int PC_SIDE  = 0;
  localparam int TGT_SIDE = 1;

  logic [ADDR_W-1:0] mapAddr [2];
  logic [IDX_W-1:0]  mapIdx  [2];
  logic              mapOk   [2];

  assign mapAddr[PC_SIDE]  = pcAddr;
  assign mapAddr[TGT_SIDE] = tgtAddr;

  // One region mapper per address side
  for (genvar g = 0; g < 2; g++) begin : g_map
    fguard_blkmap #(
      .ADDR_W  (ADDR_W),
      .BLK_LOG2(BLK_LOG2),
      .NUM_MAIN(NUM_MAIN),
      .BOOT_END(BOOT_END),
      .IDX_W   (IDX_W)
    ) u_map (
      .addr   (mapAddr[g]),
      .idx    (mapIdx[g]),
      .inRange(mapOk[g])
    );
  end

  logic tgtWrOpen;
  logic tgtRdOpen;
  logic sameRegion;

  always_comb begin
    tgtWrOpen = 1'b1;
    tgtRdOpen = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (mapIdx[TGT_SIDE] == IDX_W'(b)) begin
        tgtWrOpen = wrProt[b];
        tgtRdOpen = rdProt[b];
      end
    end
  end

  assign sameRegion = mapOk[PC_SIDE] && (mapIdx[PC_SIDE] == mapIdx[TGT_SIDE]);

  always_comb begin
    strobes          = '0;
    strobes.eraseUpd = eraseReq;
    strobes.cfgUpd   = cfgWrEn;
    if (accValid && mapOk[TGT_SIDE]) begin
      if (accWrite) begin
        strobes.wrPass = tgtWrOpen;
        strobes.refuse = !tgtWrOpen;
      end else if (!(tgtRdOpen || sameRegion)) begin
        strobes.rdZero = 1'b1;
        strobes.refuse = 1'b1;
      end
    end
  end

  // R3: a single access never both writes and zeroes read data
  onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrPass, strobes.rdZero}));

  // R8: out-of-map targets never refuse
  out_of_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !mapOk[TGT_SIDE]) |-> !strobes.refuse && !strobes.wrPass);

endmodule

// File: rtl/fguard_dpath.sv
module fguard_dpath
  import fguard_pkg::*;
#(
  parameter int NB     = 5,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strobes,
  input  logic [NB-1:0]     cfgWrProtIn,
  input  logic [NB-1:0]     cfgRdProtIn,
  input  logic              eraseAll,
  input  logic [IDX_W-1:0]  eraseIdx,
  input  logic [DATA_W-1:0] memRdData,
  output logic [NB-1:0]     wrProt,
  output logic [NB-1:0]     rdProt,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              zeroSel,
  output logic              violation
);

  logic [NB-1:0] eraseMask;
  logic [NB-1:0] wrNext;
  logic [NB-1:0] rdNext;

  // Regions hit by the erase command
  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign eraseMask[b] = strobes.eraseUpd && (eraseAll || (eraseIdx == IDX_W'(b)));
  end

  always_comb begin
    wrNext = wrProt;
    rdNext = rdProt;
    if (strobes.cfgUpd) begin
      wrNext = wrNext & cfgWrProtIn;
      rdNext = rdNext & cfgRdProtIn;
    end
    wrNext = wrNext | eraseMask;
    rdNext = rdNext | eraseMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrProt    <= '1;
      rdProt    <= '1;
      violation <= 1'b0;
    end else begin
      wrProt    <= wrNext;
      rdProt    <= rdNext;
      violation <= strobes.refuse;
    end
  end

  assign zeroSel   = strobes.rdZero;
  assign rdDataOut = zeroSel ? '0 : memRdData;

  // R5
  no_rise_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.eraseUpd |=> ((wrProt & ~$past(wrProt)) == '0));

  // R5
  no_rise_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.eraseUpd |=> ((rdProt & ~$past(rdProt)) == '0));

  // R6
  erase_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eraseUpd && eraseAll) |=> (&wrProt && &rdProt));

  // R2
  zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroSel |-> (rdDataOut == '0));

endmodule

// File: rtl/fguard_top.sv
module fguard_top
  import fguard_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int BLK_LOG2 = 14,
  parameter int NUM_MAIN = 4,
  parameter int BOOT_END = 512,
  localparam int NB      = NUM_MAIN + 1,
  localparam int IDX_W   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] pcAddr,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              cfgWrEn,
  input  logic [NB-1:0]     cfgWrProtIn,
  input  logic [NB-1:0]     cfgRdProtIn,
  input  logic              eraseReq,
  input  logic              eraseAll,
  input  logic [IDX_W-1:0]  eraseIdx,
  output logic              memWrEn,
  output logic              zeroSel,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              violation,
  output logic [NB-1:0]     wrProtBits,
  output logic [NB-1:0]     rdProtBits
);

  guardStrobes_t strobes;

  fguard_ctrl #(
    .ADDR_W  (ADDR_W),
    .BLK_LOG2(BLK_LOG2),
    .NUM_MAIN(NUM_MAIN),
    .BOOT_END(BOOT_END),
    .NB      (NB),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .accValid(accValid),
    .accWrite(accWrite),
    .pcAddr  (pcAddr),
    .tgtAddr (tgtAddr),
    .cfgWrEn (cfgWrEn),
    .eraseReq(eraseReq),
    .wrProt  (wrProtBits),
    .rdProt  (rdProtBits),
    .strobes (strobes)
  );

  fguard_dpath #(
    .NB    (NB),
    .IDX_W (IDX_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgWrProtIn(cfgWrProtIn),
    .cfgRdProtIn(cfgRdProtIn),
    .eraseAll   (eraseAll),
    .eraseIdx   (eraseIdx),
    .memRdData  (memRdData),
    .wrProt     (wrProtBits),
    .rdProt     (rdProtBits),
    .rdDataOut  (rdDataOut),
    .zeroSel    (zeroSel),
    .violation  (violation)
  );

  assign memWrEn = strobes.wrPass;

  // R1: a write that reached the array is never flagged
  passed_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !violation);

  // R1: a write access that was held off while the target is in the map is flagged
  held_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !memWrEn && (wrProtBits != '1)
      && (tgtAddr < ADDR_W'(NUM_MAIN) << BLK_LOG2)) |=> violation);

endmodule

// File: tb/fguard_tb_top.sv
module fguard_tb_top;

  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;
  localparam int NB     = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              accValid = 1'b0;
  logic              accWrite = 1'b0;
  logic [ADDR_W-1:0] pcAddr = '0;
  logic [ADDR_W-1:0] tgtAddr = '0;
  logic [DATA_W-1:0] memRdData;
  logic              cfgWrEn = 1'b0;
  logic [NB-1:0]     cfgWrProtIn = '1;
  logic [NB-1:0]     cfgRdProtIn = '1;
  logic              eraseReq = 1'b0;
  logic              eraseAll = 1'b0;
  logic [2:0]        eraseIdx = '0;
  logic              memWrEn;
  logic              zeroSel;
  logic [DATA_W-1:0] rdDataOut;
  logic              violation;
  logic [NB-1:0]     wrProtBits;
  logic [NB-1:0]     rdProtBits;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Bench memory model: data depends on the target address
  assign memRdData = tgtAddr[15:0] ^ 16'hA5C3;

  fguard_top dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .pcAddr(pcAddr), .tgtAddr(tgtAddr), .memRdData(memRdData),
    .cfgWrEn(cfgWrEn), .cfgWrProtIn(cfgWrProtIn), .cfgRdProtIn(cfgRdProtIn),
    .eraseReq(eraseReq), .eraseAll(eraseAll), .eraseIdx(eraseIdx),
    .memWrEn(memWrEn), .zeroSel(zeroSel), .rdDataOut(rdDataOut),
    .violation(violation), .wrProtBits(wrProtBits), .rdProtBits(rdProtBits)
  );

  typedef struct {
    logic              wrEn;
    logic              zero;
    logic [DATA_W-1:0] data;
    logic              viol;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];

  // Bench copy of the guard bits
  logic [NB-1:0] wpM = '1;
  logic [NB-1:0] rpM = '1;

  function automatic void regionOf(input logic [ADDR_W-1:0] a, output int idx, output bit ok);
    if (a < 21'h200) begin
      idx = 0; ok = 1;
    end else if (int'(a / 21'h4000) < 4) begin
      idx = int'(a / 21'h4000) + 1; ok = 1;
    end else begin
      idx = 0; ok = 0;
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: present one access for one cycle and push what must come out
  task automatic access(input bit wr, input logic [ADDR_W-1:0] pc,
                        input logic [ADDR_W-1:0] tgt, input string tag);
    expItem_t e;
    int pIdx, tIdx;
    bit pOk, tOk, open;
    regionOf(pc, pIdx, pOk);
    regionOf(tgt, tIdx, tOk);
    e.tag = tag;
    e.wrEn = 0; e.zero = 0; e.viol = 0;
    if (tOk) begin
      if (wr) begin
        open = wpM[tIdx];
        e.wrEn = open; e.viol = !open;
      end else begin
        open = rpM[tIdx] || (pOk && pIdx == tIdx);
        e.zero = !open; e.viol = !open;
      end
    end
    e.data = e.zero ? '0 : (tgt[15:0] ^ 16'hA5C3);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; pcAddr = pc; tgtAddr = tgt;
    expQ.push_back(e);
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic cfgWrite(input logic [NB-1:0] w, input logic [NB-1:0] r);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrProtIn = w; cfgRdProtIn = r;
    @(negedge clk);
    cfgWrEn = 1'b0;
    wpM = wpM & w; rpM = rpM & r;
  endtask

  task automatic erase(input bit all, input logic [2:0] idx, input bit withCfg);
    @(negedge clk);
    eraseReq = 1'b1; eraseAll = all; eraseIdx = idx;
    if (withCfg) begin
      cfgWrEn = 1'b1; cfgWrProtIn = '0; cfgRdProtIn = '0;
    end
    @(negedge clk);
    eraseReq = 1'b0; cfgWrEn = 1'b0;
    if (withCfg) begin
      wpM = '0; rpM = '0;
    end
    if (all) begin
      wpM = '1; rpM = '1;
    end else begin
      wpM[idx] = 1'b1; rpM[idx] = 1'b1;
    end
  endtask

  // Monitor: comb outputs of the held access and the flag registered at this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (accValid && expQ.size() > 0) begin
          expItem_t e;
          e = expQ.pop_front();
          check({e.tag, " memWrEn"}, 32'(memWrEn), 32'(e.wrEn));
          check({e.tag, " zeroSel"}, 32'(zeroSel), 32'(e.zero));
          check({e.tag, " rdDataOut"}, 32'(rdDataOut), 32'(e.data));
          check({e.tag, " violation"}, 32'(violation), 32'(e.viol));
        end else if (!accValid) begin
          check("R1/R2 idle flag", 32'(violation), 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 wrProtBits", 32'(wrProtBits), 32'h1F);
    check("R7 rdProtBits", 32'(rdProtBits), 32'h1F);
    check("R7 memWrEn", 32'(memWrEn), 32'd0);
    check("R7 violation", 32'(violation), 32'd0);

    // R3 everything open
    access(1, 21'h00100, 21'h05000, "R3 open write");
    access(0, 21'h00100, 21'h0C123, "R3 open read");

    // R1 write-guard main region 0 (bit 1)
    cfgWrite(5'b11101, 5'b11111);
    check("R5 wr bit lowered", 32'(wrProtBits), 32'h1D);
    access(1, 21'h00300, 21'h00200, "R1 guarded write region0 low edge");
    access(1, 21'h00300, 21'h03FFF, "R1 guarded write region0 high edge");
    access(1, 21'h00300, 21'h04000, "R4 write next region open");
    access(1, 21'h00300, 21'h001FF, "R4 write boot open");
    access(0, 21'h08000, 21'h02000, "R9 read of write-guarded region");

    // R2 read-guard main region 2 (bit 3)
    cfgWrite(5'b11111, 5'b10111);
    access(0, 21'h09000, 21'h0A000, "R2 read from same region");
    access(0, 21'h04000, 21'h0A000, "R2 read from other region");
    access(0, 21'h00010, 21'h08000, "R2 read from boot");
    access(0, 21'h10000, 21'h08000, "R2 read from above map");
    access(1, 21'h00010, 21'h0A000, "R9 write to read-guarded region");

    // R2/R4 boot region read guard (bit 0)
    cfgWrite(5'b11111, 5'b11110);
    access(0, 21'h00100, 21'h00050, "R2 boot read from boot");
    access(0, 21'h00300, 21'h00050, "R2 boot read from region0");
    access(0, 21'h00300, 21'h00200, "R4 region0 read not boot");
    access(0, 21'h00300, 21'h001FF, "R4 boot top read");

    // R5 attempt to raise bits
    cfgWrite(5'b11111, 5'b11111);
    check("R5 no rise wr", 32'(wrProtBits), 32'h1D);
    check("R5 no rise rd", 32'(rdProtBits), 32'h16);
    access(1, 21'h00300, 21'h01000, "R5 still write-guarded");

    // R8 beyond map
    cfgWrite(5'b00000, 5'b00000);
    access(1, 21'h00300, 21'h10000, "R8 write beyond map");
    access(0, 21'h00300, 21'h10004, "R8 read beyond map");

    // R6 single region erase (region 2, bit 3)
    erase(0, 3'd3, 0);
    check("R6 erase one wr", 32'(wrProtBits), 32'h08);
    check("R6 erase one rd", 32'(rdProtBits), 32'h08);
    access(0, 21'h00100, 21'h0B000, "R6 erased region readable");
    access(1, 21'h00100, 21'h0C000, "R6 other region still guarded");

    // R6 erase together with a lowering write: erase wins on region 1
    erase(0, 3'd2, 1);
    check("R6 erase beats cfg wr", 32'(wrProtBits), 32'h04);
    check("R6 erase beats cfg rd", 32'(rdProtBits), 32'h04);

    // R6 erase all
    erase(1, 3'd0, 0);
    check("R6 erase all wr", 32'(wrProtBits), 32'h1F);
    check("R6 erase all rd", 32'(rdProtBits), 32'h1F);
    access(1, 21'h00100, 21'h00020, "R6 boot write after erase all");

    repeat (4) @(negedge clk);
    check("R1/R2 queue drained", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule